// File: doc/BRIEF.md
# Float Uniform Vector Assembler

This block turns a stream of 32-bit register writes into four-component 24-bit floating-point vectors. It stores them in a register file of 96 vectors. A setup write chooses the input format and a destination index. In float32 mode each vector takes four words, and each word is narrowed to the 24-bit float format. In packed mode each vector takes three words, which already hold the four 24-bit components back to back. When a vector completes it is stored, and the destination index steps forward, so a run of vectors can be loaded with a single setup write.

The block holds two identical units. A write is steered to one unit by `unitSel`. When `sharedMode` is high, every write aimed at the primary unit is also applied to the secondary unit. Each unit keeps its own staging words, word counter, format bit and index. Both register files can be read at any time through a combinational read port.

The 24-bit format has 1 sign bit, then 7 exponent bits with bias 63, then 16 mantissa bits.

Top module: `funi_assembler`

## Requirements
- R1: Each data write is staged and counted. The vector completes on the 3rd word in packed mode, or on the 4th word in float32 mode. The counter then returns to zero. The stored vector is visible on the read port right after the clock edge that captured the completing word. Before that edge the entry keeps its old value.
- R2: In packed mode, a completed vector stores the three words as {word0, word1, word2} across the 96-bit entry. Component w is bits [95:72], z is [71:48], y is [47:24] and x is [23:0].
- R3: In float32 mode, the converted first word goes to w [95:72] and the converted fourth word goes to x [23:0], in reverse arrival order.
- R4: A vector that completes while the index is 96 or above is discarded. `errFlag` for that unit is high for exactly the one cycle after the completing write. The index is left unchanged.
- R5: After every stored vector, the unit's index increases by one.
- R6: A setup write replaces the format bit and the index. Bit 31 selects float32 when set and packed when clear. Bits [7:0] give the index.
- R7: When `sharedMode` is high, setup and data writes to unit 0 also act on unit 1. Writes to unit 1 never reach unit 0. The two units count and index on their own.
- R8: Float32 conversion keeps the sign and subtracts 64 from the exponent field. It keeps mantissa bits [22:7] and drops the rest.
- R9: A float32 exponent field of 64 or below becomes a zero with the same sign. A field of 192 or above saturates to exponent 127 and mantissa 0xFFFF with the same sign.
- R10: A setup write and a completing data write may arrive in the same cycle. The vector is then stored under the old format and old index, and the index takes the setup value without incrementing.
- R11: A synchronous active-high reset clears both counters, both indices, both format bits (to packed) and both register files.
- R12: `rdUnit` selects the register file that is read. An `rdAddr` of 96 or above reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| setupWr | input | 1 | Write `wrData` to the setup register |
| dataWr | input | 1 | Write `wrData` as a vector word |
| unitSel | input | 1 | Target unit: 0 primary, 1 secondary |
| sharedMode | input | 1 | Mirror unit 0 writes into unit 1 |
| wrData | input | 32 | Write data shared by setup and data writes |
| rdUnit | input | 1 | Register file selected for reading |
| rdAddr | input | 7 | Vector read address |
| rdVec | output | 96 | Vector read data {w,z,y,x} |
| idxPri | output | 8 | Current index of unit 0 |
| idxSec | output | 8 | Current index of unit 1 |
| errFlag | output | 2 | Per-unit pulse for a discarded vector |

## Verification
The setup register update and the vector commit can fall in the same cycle. Both change the index, and both depend on the format bit. The bench provokes this by sending the last word of a packed vector together with a setup write. That word has bit 31 set and a new index in its low byte. The bench then checks three things: the vector landed at the old index in packed layout, the index equals the new setup value rather than old plus one, and the next four words are taken as float32 at the new index.

// File: rtl/funi_pkg.sv
package funi_pkg;
  localparam int WORD_W     = 32;
  localparam int COMP_W     = 24;
  localparam int NCOMP      = 4;
  localparam int VEC_W      = COMP_W * NCOMP;
  localparam int IDX_W      = 8;
  localparam int PACK_WORDS = (VEC_W + WORD_W - 1) / WORD_W;
  localparam int F32_WORDS  = NCOMP;
  localparam int CNT_W      = $clog2(F32_WORDS + 1);
  localparam int SLOT_W     = $clog2(F32_WORDS);
  localparam int EXP_SHIFT  = 64;   // 127 - 63
  localparam int EXP_TOP    = 192;  // first float32 exponent beyond range

  typedef struct packed {
    logic              stage;
    logic [SLOT_W-1:0] slot;
    logic              commit;
    logic              fmt32;
    logic [IDX_W-1:0]  dest;
  } ctlStrobe_t;

  function automatic logic [COMP_W-1:0] f32ToF24(input logic [WORD_W-1:0] f);
    logic       s;
    logic [7:0] e;
    logic [7:0] ne;
    logic [COMP_W-1:0] r;
    s  = f[31];
    e  = f[30:23];
    ne = e - 8'(EXP_SHIFT);
    if (e <= 8'(EXP_SHIFT))
      r = {s, 23'd0};
    else if (e >= 8'(EXP_TOP))
      r = {s, 7'h7F, 16'hFFFF};
    else
      r = {s, ne[6:0], f[22:7]};
    return r;
  endfunction
endpackage

// File: rtl/funi_ctrl.sv
module funi_ctrl
  import funi_pkg::*;
#(
  parameter int DEPTH = 96
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             setWr,
  input  logic             datWr,
  input  logic             fmtIn,
  input  logic [IDX_W-1:0] idxIn,
  output ctlStrobe_t       strb,
  output logic [IDX_W-1:0] idxOut,
  output logic             errOut
);
  localparam logic [IDX_W-1:0] LIMIT = IDX_W'(DEPTH);

  logic             fmt32Q;
  logic [IDX_W-1:0] idxQ;
  logic [CNT_W-1:0] cntQ;
  logic             errQ;
  logic [CNT_W-1:0] need;
  logic [CNT_W-1:0] cntInc;
  logic             fire;
  logic             inRange;

  always_comb begin
    need    = fmt32Q ? CNT_W'(F32_WORDS) : CNT_W'(PACK_WORDS);
    cntInc  = cntQ + 1'b1;
    fire    = datWr && (cntInc >= need);
    inRange = idxQ < LIMIT;
    strb.stage  = datWr && !fire;
    strb.slot   = cntQ[SLOT_W-1:0];
    strb.commit = fire && inRange;
    strb.fmt32  = fmt32Q;
    strb.dest   = idxQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fmt32Q <= 1'b0;
      idxQ   <= '0;
      cntQ   <= '0;
      errQ   <= 1'b0;
    end else begin
      errQ <= fire && !inRange;
      if (datWr) cntQ <= fire ? '0 : cntInc;
      if (setWr) begin
        fmt32Q <= fmtIn;
        idxQ   <= idxIn;
      end else if (fire && inRange) begin
        idxQ <= idxQ + 1'b1;
      end
    end
  end

  assign idxOut = idxQ;
  assign errOut = errQ;

  // R1: a completed vector returns the counter to zero
  p_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    (datWr && !strb.stage) |=> cntQ == '0);
  // R1: a staged word advances the counter by one
  p_count_r1: assert property (@(posedge clk) disable iff (rst)
    strb.stage |=> cntQ == CNT_W'($past(cntQ) + 1'b1));
  // R5: a stored vector advances the index
  p_step_r5: assert property (@(posedge clk) disable iff (rst)
    (strb.commit && !setWr) |=> idxQ == IDX_W'($past(idxQ) + 1'b1));
  // R4: a discarded vector flags an error and holds the index
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (datWr && !strb.stage && !strb.commit && !setWr) |=> (errOut && idxQ == $past(idxQ)));
  // R6 / R10: setup value always wins over the increment
  p_setup_r6: assert property (@(posedge clk) disable iff (rst)
    setWr |=> (idxQ == $past(idxIn) && fmt32Q == $past(fmtIn)));
  // R4: the error pulse lasts one cycle unless a new failing vector follows
  p_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    (errOut && !datWr) |=> !errOut);
endmodule

// File: rtl/funi_dpath.sv
module funi_dpath
  import funi_pkg::*;
#(
  parameter int DEPTH = 96,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  ctlStrobe_t        strb,
  input  logic [WORD_W-1:0] wdata,
  input  logic [AW-1:0]     rdAddr,
  output logic [VEC_W-1:0]  rdVec
);
  logic [WORD_W-1:0] stageQ [PACK_WORDS];
  logic [WORD_W-1:0] words  [F32_WORDS];
  logic [COMP_W-1:0] cvt    [F32_WORDS];
  logic [VEC_W-1:0]  rf     [DEPTH];
  logic [VEC_W-1:0]  vec32;
  logic [VEC_W-1:0]  vecPk;

  // the word arriving now bypasses the staging registers
  for (genvar k = 0; k < F32_WORDS; k++) begin : g_word
    if (k < PACK_WORDS) begin : g_staged
      assign words[k] = (strb.slot == SLOT_W'(k)) ? wdata : stageQ[k];
    end else begin : g_last
      assign words[k] = wdata;
    end
    assign cvt[k] = f32ToF24(words[k]);
  end

  always_comb begin
    vec32 = '0;
    vecPk = '0;
    for (int k = 0; k < F32_WORDS; k++)
      vec32[VEC_W-1-k*COMP_W -: COMP_W] = cvt[k];
    for (int k = 0; k < PACK_WORDS; k++)
      vecPk[VEC_W-1-k*WORD_W -: WORD_W] = words[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < PACK_WORDS; k++) stageQ[k] <= '0;
      for (int i = 0; i < DEPTH; i++) rf[i] <= '0;
    end else begin
      if (strb.stage && strb.slot < SLOT_W'(PACK_WORDS))
        stageQ[strb.slot] <= wdata;
      if (strb.commit)
        rf[AW'(strb.dest)] <= strb.fmt32 ? vec32 : vecPk;
    end
  end

  assign rdVec = ({1'b0, rdAddr} < (AW+1)'(DEPTH)) ? rf[rdAddr] : '0;

  // R4: control never commits outside the file
  p_dest_range_r4: assert property (@(posedge clk) disable iff (rst)
    strb.commit |-> strb.dest < IDX_W'(DEPTH));
  // R1: staging and committing never coincide
  p_excl_r1: assert property (@(posedge clk) disable iff (rst)
    !(strb.stage && strb.commit));
endmodule

// File: rtl/funi_assembler.sv
module funi_assembler
  import funi_pkg::*;
#(
  parameter int DEPTH  = 96,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              setupWr,
  input  logic              dataWr,
  input  logic              unitSel,
  input  logic              sharedMode,
  input  logic [WORD_W-1:0] wrData,
  input  logic              rdUnit,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [VEC_W-1:0]  rdVec,
  output logic [IDX_W-1:0]  idxPri,
  output logic [IDX_W-1:0]  idxSec,
  output logic [1:0]        errFlag
);
  localparam int NUNITS = 2;

  logic [VEC_W-1:0] vecU [NUNITS];
  logic [IDX_W-1:0] idxU [NUNITS];

  for (genvar u = 0; u < NUNITS; u++) begin : g_unit
    logic       hit;
    ctlStrobe_t strb;
    if (u == 0) begin : g_pri
      assign hit = !unitSel;
    end else begin : g_sec
      assign hit = unitSel || (sharedMode && !unitSel);
    end

    funi_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk    (clk),
      .rst    (rst),
      .setWr  (setupWr && hit),
      .datWr  (dataWr && hit),
      .fmtIn  (wrData[WORD_W-1]),
      .idxIn  (wrData[IDX_W-1:0]),
      .strb   (strb),
      .idxOut (idxU[u]),
      .errOut (errFlag[u])
    );

    funi_dpath #(.DEPTH(DEPTH), .AW(ADDR_W)) u_dpath (
      .clk    (clk),
      .rst    (rst),
      .strb   (strb),
      .wdata  (wrData),
      .rdAddr (rdAddr),
      .rdVec  (vecU[u])
    );
  end

  assign rdVec  = vecU[rdUnit];
  assign idxPri = idxU[0];
  assign idxSec = idxU[1];

  // R7: shared mode copies primary setup writes into the secondary
  p_mirror_r7: assert property (@(posedge clk) disable iff (rst)
    (sharedMode && !unitSel && setupWr) |=> idxSec == $past(wrData[IDX_W-1:0]));
  // R7: writes to the secondary never disturb the primary
  p_direct_r7: assert property (@(posedge clk) disable iff (rst)
    (unitSel && (setupWr || dataWr)) |=> $stable(idxPri));
endmodule

// File: tb/sim_funi_assembler.sv
module sim_funi_assembler;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        setupWr = 1'b0, dataWr = 1'b0, unitSel = 1'b0, sharedMode = 1'b0;
  logic [31:0] wrData = '0;
  logic        rdUnit = 1'b0;
  logic [6:0]  rdAddr = '0;
  logic [95:0] rdVec;
  logic [7:0]  idxPri, idxSec;
  logic [1:0]  errFlag;
  int applied = 0;
  int miscompares = 0;
  bit done = 0;

  always #4 clk = ~clk;

  funi_assembler u0 (
    .clk(clk), .rst(rst), .setupWr(setupWr), .dataWr(dataWr), .unitSel(unitSel),
    .sharedMode(sharedMode), .wrData(wrData), .rdUnit(rdUnit), .rdAddr(rdAddr),
    .rdVec(rdVec), .idxPri(idxPri), .idxSec(idxSec), .errFlag(errFlag)
  );

  task automatic chk(input string req, input logic [95:0] act, input logic [95:0] exp);
    applied++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic s, input logic d, input logic u, input logic [31:0] v);
    setupWr = s; dataWr = d; unitSel = u; wrData = v;
    @(negedge clk);
    setupWr = 1'b0; dataWr = 1'b0;
  endtask

  task automatic peek(input logic u, input int a, output logic [95:0] v);
    rdUnit = u; rdAddr = 7'(a);
    #1;
    v = rdVec;
  endtask

  task automatic t_reset;
    logic [95:0] v;
    peek(0, 0, v);  chk("R11 rf0[0]", v, '0);
    peek(1, 95, v); chk("R11 rf1[95]", v, '0);
    chk("R11 idxPri", 96'(idxPri), '0);
    chk("R11 idxSec", 96'(idxSec), '0);
    chk("R11 err", 96'(errFlag), '0);
  endtask

  task automatic t_packed;
    logic [95:0] v;
    put(1, 0, 0, 32'h0000_0005);
    chk("R6 setup index", 96'(idxPri), 96'd5);
    put(0, 1, 0, 32'h1122_3344);
    put(0, 1, 0, 32'h5566_7788);
    peek(0, 5, v); chk("R1 not yet stored", v, '0);
    put(0, 1, 0, 32'h99AA_BBCC);
    peek(0, 5, v); chk("R2 packed layout", v, 96'h1122_3344_5566_7788_99AA_BBCC);
    chk("R5 index step", 96'(idxPri), 96'd6);
    put(0, 1, 0, 32'hDEAD_BEEF);
    put(0, 1, 0, 32'h0102_0304);
    put(0, 1, 0, 32'hCAFE_F00D);
    peek(0, 6, v); chk("R5 next vector", v, 96'hDEAD_BEEF_0102_0304_CAFE_F00D);
    chk("R5 index step 2", 96'(idxPri), 96'd7);
    chk("R7 secondary untouched idx", 96'(idxSec), '0);
    peek(1, 5, v); chk("R7 secondary untouched rf", v, '0);
  endtask

  task automatic t_float32;
    logic [95:0] v;
    put(1, 0, 0, 32'h8000_000A);
    put(0, 1, 0, 32'h3F80_0000);   // 1.0
    put(0, 1, 0, 32'hBFC0_0000);   // -1.5
    put(0, 1, 0, 32'h3F00_0000);   // 0.5
    peek(0, 10, v); chk("R1 float32 needs four", v, '0);
    put(0, 1, 0, 32'h4000_0000);   // 2.0
    peek(0, 10, v); chk("R3 R8 reversed order", v, 96'h3F0000_BF8000_3E0000_400000);
    put(0, 1, 0, 32'h2000_0000);   // exponent 64 -> zero
    put(0, 1, 0, 32'h8080_0000);   // tiny negative -> -0
    put(0, 1, 0, 32'h7F00_0000);   // huge -> saturate
    put(0, 1, 0, 32'h2080_0000);   // exponent 65 -> smallest
    peek(0, 11, v); chk("R9 underflow and saturation", v, 96'h000000_800000_7FFFFF_010000);
    chk("R5 float32 index", 96'(idxPri), 96'd12);
  endtask

  task automatic t_bad_index;
    logic [95:0] v;
    put(1, 0, 0, 32'h0000_005F);
    put(0, 1, 0, 32'hAAAA_0001);
    put(0, 1, 0, 32'hAAAA_0002);
    put(0, 1, 0, 32'hAAAA_0003);
    peek(0, 95, v); chk("R1 last entry", v, 96'hAAAA_0001_AAAA_0002_AAAA_0003);
    chk("R5 index 96", 96'(idxPri), 96'd96);
    put(0, 1, 0, 32'hBBBB_0001);
    put(0, 1, 0, 32'hBBBB_0002);
    chk("R4 no early error", 96'(errFlag), '0);
    put(0, 1, 0, 32'hBBBB_0003);
    chk("R4 error pulse", 96'(errFlag), 96'd1);
    chk("R4 index held", 96'(idxPri), 96'd96);
    peek(0, 95, v); chk("R4 entry kept", v, 96'hAAAA_0001_AAAA_0002_AAAA_0003);
    peek(0, 96, v); chk("R12 out of range read", v, '0);
    @(negedge clk);
    chk("R4 pulse ends", 96'(errFlag), '0);
  endtask

  task automatic t_collision;
    logic [95:0] v;
    put(1, 0, 0, 32'h0000_0014);
    put(0, 1, 0, 32'h0BAD_0001);
    put(0, 1, 0, 32'h0BAD_0002);
    put(1, 1, 0, 32'h8000_001E);
    peek(0, 20, v); chk("R10 stored at old index", v, 96'h0BAD_0001_0BAD_0002_8000_001E);
    chk("R10 index from setup", 96'(idxPri), 96'd30);
    peek(0, 30, v); chk("R10 new index empty", v, '0);
    put(0, 1, 0, 32'h3F80_0000);
    put(0, 1, 0, 32'h3F80_0000);
    put(0, 1, 0, 32'h3F80_0000);
    put(0, 1, 0, 32'h4000_0000);
    peek(0, 30, v); chk("R6 format switched", v, 96'h3F0000_3F0000_3F0000_400000);
  endtask

  task automatic t_shared;
    logic [95:0] v;
    sharedMode = 1'b1;
    put(1, 0, 0, 32'h0000_0028);
    chk("R7 mirrored setup", 96'(idxSec), 96'd40);
    put(0, 1, 0, 32'hA0A0_A0A0);
    put(0, 1, 0, 32'hB1B1_B1B1);
    put(0, 1, 0, 32'hC2C2_C2C2);
    peek(0, 40, v); chk("R7 primary vector", v, 96'hA0A0A0A0_B1B1B1B1_C2C2C2C2);
    peek(1, 40, v); chk("R7 R12 secondary vector", v, 96'hA0A0A0A0_B1B1B1B1_C2C2C2C2);
    put(1, 0, 1, 32'h0000_0032);
    chk("R7 direct setup secondary", 96'(idxSec), 96'd50);
    chk("R7 primary not touched", 96'(idxPri), 96'd41);
    put(0, 1, 0, 32'hD3D3_D3D3);
    sharedMode = 1'b0;
    put(0, 1, 1, 32'hE4E4_E4E4);
    put(0, 1, 1, 32'hF5F5_F5F5);
    peek(1, 50, v); chk("R7 secondary own counter", v, 96'hD3D3D3D3_E4E4E4E4_F5F5F5F5);
    peek(0, 41, v); chk("R7 primary unaffected", v, '0);
    chk("R7 primary index", 96'(idxPri), 96'd41);
    put(0, 1, 0, 32'h0102_0304);
    put(0, 1, 0, 32'h0506_0708);
    peek(0, 41, v); chk("R7 primary own counter", v, 96'hD3D3D3D3_01020304_05060708);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_packed();
    t_float32();
    t_bad_index();
    t_collision();
    t_shared();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end
endmodule